// File: doc/BRIEF.md
# Two-Level Context Address Translator

This block turns 32-bit virtual addresses into physical addresses in two steps. The first step indexes a segment table that holds one set of entries for each hardware context. Each segment entry names a group of 32 page entries. The second step reads the selected page entry. It supplies a 19-bit physical page number, a valid flag, an accessed flag and a 2-bit type code. The type code steers the access either to main memory or to device space. Pages are 8 KB, so the low 13 address bits pass through unchanged.

All traffic arrives on a single request port that carries an address, a 4-bit space code, a write flag, a byte mask and write data. Space code 2 reaches the context register, 3 reaches the segment table, 4 reaches the page table, and 8 to 11 are translated accesses. Software loads the tables through this port, then switches contexts and issues translated traffic on the same port. Before boot completes, every supervisor instruction fetch (space 9) is redirected to boot ROM without translation. An access whose page entry is not valid produces a one-cycle fault pulse and never reaches memory.

In the default build the tables are scaled down to 16 contexts, 64 segments per context and 8 page groups. The segment index is taken from the low bits of the virtual address field that starts at bit 18.

Top module: `ctx_seg_mmu`

## Requirements
- R1: A translated access (space 8 to 11) drives `dn_addr` = {page entry bits 18:0, virtual address bits 12:0}. The segment entry comes from the current context, at index VA[18 +: SEG_W], and names the page group. The page entry is entry VA[17:13] of that group. The same virtual address in two contexts reaches different entries.
- R2: A write in space 2 with VA[31:28] = 3 sets the context register. With mask 1000 the value comes from bits 31:24, with mask 1100 it comes from bits 23:16, and any other mask leaves the register unchanged. A read returns the context in bits 31:24, or in bits 23:16 when the mask is 0100.
- R3: A segment table write (space 3) takes its value from bits 31:24 with mask 1000, or from bits 23:16 with mask 1100. Any other mask leaves the entry unchanged. A read returns the entry in bits 31:24.
- R4: A page table write (space 4) is byte-masked and stores bits 23:19 as zero. A page table read returns the stored word.
- R5: A translated access that hits a valid entry (bit 31) sets the accessed bit (bit 25) in the stored entry.
- R6: Page entry bits 27:26 select the target. Type 0 sends the access downstream with `dn_is_dev`=0, and type 1 sends it with `dn_is_dev`=1. Any other type sends nothing downstream: a read returns a response of zero and a write is dropped.
- R7: A translated access to an entry with bit 31 clear raises `fault` for exactly one cycle, issues no downstream access and does not set the accessed bit.
- R8: A translated access whose VA[31:30] is 01 or 10 raises `fault` one cycle after acceptance, without any table lookup. Addresses with 00 or 11 in those bits translate normally.
- R9: While `boot_done` is low, a space-9 request raises `rom_valid` one cycle later with `rom_addr` = VA[2 +: ROM_AW], and nothing goes downstream. While `boot_done` is high, space 9 is translated.
- R10: After reset all pulse outputs are low and `req_ready` is high. Context and ROM operations complete one cycle after acceptance. Segment table operations complete after two cycles. Page table and translated operations complete after three cycles. `req_ready` stays low until the operation has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_done | input | 1 | Low while in boot mode (supervisor fetches go to ROM) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Virtual or control address |
| req_space | input | 4 | Access-space code |
| req_write | input | 1 | 1 = write |
| req_be | input | 4 | Byte mask, bit 3 = bits 31:24 |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data returned by the block |
| rsp_rdata | output | 32 | Returned read data |
| dn_valid | output | 1 | Downstream access pulse |
| dn_addr | output | 32 | Physical byte address |
| dn_is_dev | output | 1 | 1 = device space, 0 = main memory |
| dn_write | output | 1 | Downstream write flag |
| dn_be | output | 4 | Downstream byte mask |
| dn_wdata | output | 32 | Downstream write data |
| rom_valid | output | 1 | Boot ROM fetch pulse |
| rom_addr | output | ROM_AW | ROM word address |
| fault | output | 1 | Translation fault pulse |

## Verification
A corrupted segment entry or context register shows up in the same cycle as the downstream pulse, three cycles after acceptance: the physical page number is wrong, or the access faults where it should translate. A lost accessed-bit write-back or a missing clear of bits 23:19 stays invisible until software reads the entry back, so the bench follows each affected translation with a page read. Latency faults show up as a pulse in the wrong cycle. The bench therefore samples every result at the exact cycle the requirement fixes.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  localparam int OFS_W     = 13;
  localparam int ENT_W     = 5;
  localparam int PPN_W     = 19;
  localparam int PTE_VALID = 31;
  localparam int PTE_TYPE  = 26;
  localparam logic [31:0] PTE_ZERO_MASK = 32'h00F8_0000;
  localparam logic [7:0]  ACC_LANE_BIT  = 8'h02;  // bit 25 inside bits 31:24

  localparam logic [3:0] SP_SYS   = 4'd2;
  localparam logic [3:0] SP_SEG   = 4'd3;
  localparam logic [3:0] SP_PTE   = 4'd4;
  localparam logic [3:0] SP_FETCH = 4'd9;
  localparam logic [3:0] CTX_SEL  = 4'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_SEG, ST_PTE} mmu_state_e;
  typedef enum logic [2:0] {OP_SEG_RD, OP_SEG_WR, OP_PTE_RD, OP_PTE_WR, OP_XLATE} mmu_op_e;
endpackage

// File: rtl/mmu_sp_ram.sv
module mmu_sp_ram #(
  parameter int LANES  = 1,
  parameter int LANE_W = 8,
  parameter int AW     = 8
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we,
  input  logic [AW-1:0]           addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (we[l]) mem[addr] <= wdata[l*LANE_W +: LANE_W];
      q <= mem[addr];
    end
    assign rdata[l*LANE_W +: LANE_W] = q;
  end
endmodule

// File: rtl/ctx_seg_mmu.sv
module ctx_seg_mmu
  import mmu_pkg::*;
#(
  parameter int CTX_W  = 4,
  parameter int SEG_W  = 6,
  parameter int GRP_W  = 3,
  parameter int ROM_AW = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boot_done,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_addr,
  input  logic [3:0]        req_space,
  input  logic              req_write,
  input  logic [3:0]        req_be,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              dn_valid,
  output logic [31:0]       dn_addr,
  output logic              dn_is_dev,
  output logic              dn_write,
  output logic [3:0]        dn_be,
  output logic [31:0]       dn_wdata,
  output logic              rom_valid,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              fault
);
  localparam int SEG_AW = CTX_W + SEG_W;
  localparam int PTE_AW = GRP_W + ENT_W;
  localparam int SEG_LO = OFS_W + ENT_W;

  mmu_state_e state;
  mmu_op_e    op;

  logic [CTX_W-1:0] ctx_q;
  logic [OFS_W-1:0] r_ofs;
  logic [ENT_W-1:0] r_ent;
  logic [SEG_W-1:0] r_seg;
  logic [31:0]      r_wdata;
  logic [3:0]       r_be;
  logic             r_write;

  logic [SEG_AW-1:0] seg_addr;
  logic              seg_we;
  logic [GRP_W-1:0]  seg_wdata, seg_rd;
  logic [PTE_AW-1:0] pte_addr, pte_addr_q;
  logic [3:0]        pte_we;
  logic [31:0]       pte_wdata, pte_rd;
  logic [8:0]        ctx_pick, seg_pick;
  logic [7:0]        ctx8;
  logic              range_bad;
  logic              unused_bits;

  function automatic logic [8:0] lane_pick(input logic [3:0] be, input logic [31:0] d);
    if (be == 4'b1100) return {1'b1, d[23:16]};
    if (be == 4'b1000) return {1'b1, d[31:24]};
    return 9'd0;
  endfunction

  assign req_ready = (state == ST_IDLE);
  assign range_bad = req_addr[31] ^ req_addr[30];
  assign ctx_pick  = lane_pick(req_be, req_wdata);
  assign seg_pick  = lane_pick(r_be, r_wdata);
  assign ctx8      = 8'(ctx_q);
  assign unused_bits = ^{req_addr, ctx_pick, seg_pick};

  // first level: segment table
  always_comb begin
    seg_addr  = {ctx_q, (state == ST_IDLE) ? req_addr[SEG_LO +: SEG_W] : r_seg};
    seg_we    = (state == ST_SEG) && (op == OP_SEG_WR) && seg_pick[8];
    seg_wdata = seg_pick[GRP_W-1:0];
  end

  // second level: page entries
  always_comb begin
    pte_addr  = (state == ST_SEG) ? {seg_rd, r_ent} : pte_addr_q;
    pte_we    = '0;
    pte_wdata = r_wdata & ~PTE_ZERO_MASK;
    if (state == ST_SEG && op == OP_PTE_WR) pte_we = r_be;
    if (state == ST_PTE && op == OP_XLATE && pte_rd[PTE_VALID]) begin
      pte_we    = 4'b1000;
      pte_wdata = {pte_rd[31:24] | ACC_LANE_BIT, 24'h0};
    end
  end

  mmu_sp_ram #(.LANES(1), .LANE_W(GRP_W), .AW(SEG_AW)) u_seg_ram (
    .clk(clk), .we(seg_we), .addr(seg_addr), .wdata(seg_wdata), .rdata(seg_rd)
  );

  mmu_sp_ram #(.LANES(4), .LANE_W(8), .AW(PTE_AW)) u_pte_ram (
    .clk(clk), .we(pte_we), .addr(pte_addr), .wdata(pte_wdata), .rdata(pte_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;   op <= OP_SEG_RD;   ctx_q <= '0;
      r_ofs <= '0; r_ent <= '0; r_seg <= '0; r_wdata <= '0; r_be <= '0; r_write <= 1'b0;
      pte_addr_q <= '0;
      rsp_valid <= 1'b0; rsp_rdata <= '0;
      dn_valid <= 1'b0; dn_addr <= '0; dn_is_dev <= 1'b0; dn_write <= 1'b0;
      dn_be <= '0; dn_wdata <= '0;
      rom_valid <= 1'b0; rom_addr <= '0; fault <= 1'b0;
    end else begin
      rsp_valid <= 1'b0; rsp_rdata <= '0;
      dn_valid  <= 1'b0; rom_valid <= 1'b0; fault <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          r_ofs   <= req_addr[OFS_W-1:0];
          r_ent   <= req_addr[OFS_W +: ENT_W];
          r_seg   <= req_addr[SEG_LO +: SEG_W];
          r_wdata <= req_wdata;
          r_be    <= req_be;
          r_write <= req_write;
          if (!boot_done && req_space == SP_FETCH) begin
            rom_valid <= 1'b1;
            rom_addr  <= req_addr[2 +: ROM_AW];
          end else if (req_space == SP_SYS) begin
            if (req_addr[31:28] == CTX_SEL && req_write) begin
              if (ctx_pick[8]) ctx_q <= ctx_pick[CTX_W-1:0];
            end else if (!req_write) begin
              rsp_valid <= 1'b1;
              if (req_addr[31:28] == CTX_SEL)
                rsp_rdata <= (req_be == 4'b0100) ? {8'h0, ctx8, 16'h0} : {ctx8, 24'h0};
            end
          end else if (req_space == SP_SEG) begin
            op    <= req_write ? OP_SEG_WR : OP_SEG_RD;
            state <= ST_SEG;
          end else if (req_space == SP_PTE) begin
            op    <= req_write ? OP_PTE_WR : OP_PTE_RD;
            state <= ST_SEG;
          end else if (req_space[3:2] == 2'b10) begin
            if (range_bad) fault <= 1'b1;
            else begin
              op    <= OP_XLATE;
              state <= ST_SEG;
            end
          end else if (!req_write) begin
            rsp_valid <= 1'b1;
          end
        end
        ST_SEG: begin
          pte_addr_q <= pte_addr;
          state      <= ST_IDLE;
          if (op == OP_SEG_RD) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= {8'(seg_rd), 24'h0};
          end else if (op == OP_PTE_RD || op == OP_XLATE) begin
            state <= ST_PTE;
          end
        end
        ST_PTE: begin
          state <= ST_IDLE;
          if (op == OP_PTE_RD) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= pte_rd;
          end else if (pte_rd[PTE_VALID]) begin
            if (pte_rd[PTE_TYPE+1] == 1'b0) begin
              dn_valid  <= 1'b1;
              dn_addr   <= {pte_rd[PPN_W-1:0], r_ofs};
              dn_is_dev <= pte_rd[PTE_TYPE];
              dn_write  <= r_write;
              dn_be     <= r_be;
              dn_wdata  <= r_wdata;
            end else if (!r_write) begin
              rsp_valid <= 1'b1;
            end
          end else begin
            fault <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mmu_chk.sv
module mmu_chk (
  input logic        clk,
  input logic        rst,
  input logic        boot_done,
  input logic        req_valid,
  input logic        req_ready,
  input logic [3:0]  req_space,
  input logic [31:0] req_addr,
  input logic        dn_valid,
  input logic [31:0] dn_addr,
  input logic        rom_valid,
  input logic        fault,
  input logic        rsp_valid
);
  logic acc;
  assign acc = req_valid && req_ready;

  // R6
  one_result_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dn_valid, rom_valid, fault, rsp_valid}));

  // R9
  rom_origin_chk: assert property (@(posedge clk) disable iff (rst)
    rom_valid |-> $past(acc && req_space == 4'd9 && !boot_done));

  // R1
  dn_offset_chk: assert property (@(posedge clk) disable iff (rst)
    dn_valid |-> ($past(acc, 3) && dn_addr[12:0] == $past(req_addr[12:0], 3)));

  // R7
  fault_origin_chk: assert property (@(posedge clk) disable iff (rst)
    fault |-> ($past(acc) || $past(acc, 3)));

  // R10
  busy_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && req_space == 4'd4) |=> !req_ready);
endmodule

bind ctx_seg_mmu mmu_chk u_mmu_chk (
  .clk(clk), .rst(rst), .boot_done(boot_done), .req_valid(req_valid),
  .req_ready(req_ready), .req_space(req_space), .req_addr(req_addr),
  .dn_valid(dn_valid), .dn_addr(dn_addr), .rom_valid(rom_valid),
  .fault(fault), .rsp_valid(rsp_valid)
);

// File: tb/test_ctx_seg_mmu.sv
`timescale 1ns/1ps
module test_ctx_seg_mmu;
  logic clk = 0, rst = 1, boot_done = 0;
  logic req_valid = 0, req_write = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic [3:0] req_space = 0, req_be = 0;
  logic req_ready, rsp_valid, dn_valid, dn_is_dev, dn_write, rom_valid, fault;
  logic [31:0] rsp_rdata, dn_addr, dn_wdata;
  logic [3:0] dn_be;
  logic [14:0] rom_addr;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  localparam logic [31:0] VA_A = 32'h0004_6ABC;
  localparam logic [31:0] VA_B = VA_A + 32'h2000;
  localparam logic [31:0] VA_C = VA_A + 32'h4000;
  localparam logic [31:0] CTXR = 32'h3000_0000;

  always #2 clk = ~clk;

  ctx_seg_mmu i_ctx_seg_mmu (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] sp, input logic [31:0] a, input logic w,
                      input logic [3:0] be, input logic [31:0] d, input int extra);
    @(negedge clk);
    req_valid = 1; req_space = sp; req_addr = a; req_write = w; req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    repeat (extra) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10 ready after reset", req_ready, 1);
    chk("R10 pulses low", {dn_valid, rom_valid, fault, rsp_valid}, 0);
  endtask

  task automatic t_boot();
    send(4'd9, 32'h0000_0124, 0, 4'hF, 0, 0);
    chk("R9 rom_valid", rom_valid, 1);
    chk("R9 rom_addr", rom_addr, 15'h49);
    chk("R9 no downstream", dn_valid, 0);
    boot_done = 1;
  endtask

  task automatic t_ctx();
    send(4'd2, CTXR, 1, 4'b1000, 32'h0100_0000, 0);
    send(4'd2, CTXR, 0, 4'b1000, 0, 0);
    chk("R2 ctx read top lane", rsp_rdata, 32'h0100_0000);
    send(4'd2, CTXR, 0, 4'b0100, 0, 0);
    chk("R2 ctx read second lane", rsp_rdata, 32'h0001_0000);
    send(4'd2, CTXR, 1, 4'b0001, 32'h0000_0003, 0);
    send(4'd2, CTXR, 0, 4'b1000, 0, 0);
    chk("R2 ctx write bad mask ignored", rsp_rdata, 32'h0100_0000);
  endtask

  task automatic t_tables();
    // context 1
    send(4'd3, VA_A, 1, 4'b1000, 32'h0200_0000, 1);
    send(4'd3, VA_A, 0, 4'b1000, 0, 1);
    chk("R3 seg read top lane", rsp_rdata, 32'h0200_0000);
    send(4'd4, VA_A, 1, 4'hF, 32'h80F1_2345, 1);
    send(4'd4, VA_A, 0, 4'hF, 0, 2);
    chk("R4 pte bits 23:19 zero", rsp_rdata, 32'h8001_2345);
    // context 2
    send(4'd2, CTXR, 1, 4'b1100, 32'h0002_0000, 0);
    send(4'd3, VA_A, 1, 4'b1100, 32'h0005_0000, 1);
    send(4'd3, VA_A, 1, 4'b0001, 32'h0000_0007, 1);
    send(4'd3, VA_A, 0, 4'b1000, 0, 1);
    chk("R3 second lane write, bad mask ignored", rsp_rdata, 32'h0500_0000);
    send(4'd4, VA_A, 1, 4'hF, 32'h8400_0777, 1);
    send(4'd4, VA_B, 1, 4'hF, 32'h0000_0555, 1);
    send(4'd4, VA_C, 1, 4'hF, 32'h8800_0001, 1);
  endtask

  task automatic t_xlate();
    send(4'd2, CTXR, 1, 4'b1000, 32'h0100_0000, 0);
    send(4'd8, VA_A, 0, 4'hF, 0, 0);
    chk("R10 busy after accept", req_ready, 0);
    @(negedge clk);
    chk("R10 no early result", dn_valid, 0);
    @(negedge clk);
    chk("R1 ctx1 dn_valid", dn_valid, 1);
    chk("R1 ctx1 phys", dn_addr, 32'h2468_AABC);
    chk("R6 type0 memory", dn_is_dev, 0);
    send(4'd4, VA_A, 0, 4'hF, 0, 2);
    chk("R5 accessed bit set", rsp_rdata, 32'h8201_2345);
    send(4'd2, CTXR, 1, 4'b1000, 32'h0200_0000, 0);
    send(4'd11, VA_A, 1, 4'b0011, 32'hCAFE_F00D, 2);
    chk("R1 ctx2 phys", dn_addr, 32'h00EE_EABC);
    chk("R6 type1 device", dn_is_dev, 1);
    chk("R1 write fields", {dn_valid, dn_write, dn_be}, {1'b1, 1'b1, 4'b0011});
    chk("R1 write data", dn_wdata, 32'hCAFE_F00D);
    send(4'd9, 32'hC004_6ABC, 0, 4'hF, 0, 2);
    chk("R9 fetch translated after boot", {dn_valid, rom_valid}, 2'b10);
    chk("R8 top range allowed", dn_addr, 32'h00EE_EABC);
  endtask

  task automatic t_fault();
    send(4'd10, VA_B, 0, 4'hF, 0, 2);
    chk("R7 fault pulse", {fault, dn_valid}, 2'b10);
    @(negedge clk);
    chk("R7 fault one cycle", fault, 0);
    send(4'd4, VA_B, 0, 4'hF, 0, 2);
    chk("R7 accessed not set", rsp_rdata, 32'h0000_0555);
    send(4'd8, 32'h4004_6ABC, 0, 4'hF, 0, 0);
    chk("R8 range 01 fault", fault, 1);
    send(4'd8, 32'h8004_6ABC, 1, 4'hF, 0, 0);
    chk("R8 range 10 fault", fault, 1);
    @(negedge clk); @(negedge clk);
    chk("R8 no downstream", dn_valid, 0);
  endtask

  task automatic t_type();
    send(4'd8, VA_C, 0, 4'hF, 0, 2);
    chk("R6 unsupported read zero", {rsp_valid, dn_valid, fault}, 3'b100);
    chk("R6 unsupported data", rsp_rdata, 0);
    send(4'd8, VA_C, 1, 4'hF, 32'h1234_5678, 2);
    chk("R6 unsupported write dropped", {rsp_valid, dn_valid, fault}, 3'b000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_boot();
    t_ctx();
    t_tables();
    t_xlate();
    t_fault();
    t_type();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule